// File: doc/BRIEF.md
# Coprocessor Context Save Controller

This block is the state-save and state-restore unit of a slave-only arithmetic coprocessor. The host CPU performs every transfer: the unit never drives the bus. It only presents a word and waits for the host's acknowledge, or takes a word that the host offers. The host's handshake lines arrive from another clock domain, so each of them passes through a two-flop synchroniser before the control logic uses it.

When a save is requested, the unit picks the frame from the current activity, at the cycle in which the synchronised request edge is seen:
- If the programmer's model is empty, the frame is a single null word.
- If the execution unit is quiet, the frame is a short idle frame.
- If an operation is in flight, the remaining-cycle count is compared with the length of the full busy frame. An operation that will finish sooner is allowed to complete, and the idle frame is sent after it. A longer one is stopped with a one-cycle abort, and the full busy frame is sent.

Every frame starts with a header word. Its bits [31:30] hold the format (00 null, 01 idle, 10 busy) and its bits [5:0] hold the total frame length in words.

On restore, the host writes a frame back:
- A null header asks the rest of the coprocessor to return to its post-reset state.
- An idle or busy header reloads the matching number of context words. The unit then reports which state to resume in.

Top module: `ctx_save_unit`

## Requirements
- R1: After reset, rdValid, wrAck, exAbort, modelClear and resumeValid are all low.
- R2: A save requested while modelEmpty is high yields exactly one word, 0x00000001, and no abort.
- R3: A save requested while exBusy is low yields a 7-word frame. Its header is 0x40000007, and words 2 to 7 are context words 0 to 5.
- R4: A save requested while exBusy is high and exRemain is below 46 raises no abort. No word is presented until exBusy falls, and then the idle frame of R3 follows.
- R5: A save requested while exBusy is high and exRemain is 46 or more pulses exAbort for one cycle. It then yields a 46-word frame whose header is 0x8000002E, followed by context words 0 to 44.
- R6: Each word is held with rdValid high until the synchronised rdAck is seen high. rdValid then drops, and the next word is presented only after rdAck has been seen low.
- R7: A restore with an idle (01) or busy (10) header takes 6 or 45 further words into context words 0 onward. It then pulses resumeValid, with resumeBusy high for busy and low for idle. A later save returns the restored words.
- R8: A restore with a null (00) header takes no further words. It pulses modelClear and does not pulse resumeValid.
- R9: A restore with header code 11 takes no further words, raises no pulse and leaves the context words unchanged.
- R10: A save request that arrives while a frame is being sent is ignored: the frame keeps its length and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Coprocessor clock |
| rstN | input | 1 | Active-low asynchronous reset |
| saveReq | input | 1 | Save request from the host (asynchronous, rising edge acts) |
| restoreReq | input | 1 | Restore request from the host (asynchronous, rising edge acts) |
| exBusy | input | 1 | Execution unit has an operation in flight |
| exRemain | input | 8 | Cycles left in the in-flight operation |
| modelEmpty | input | 1 | Programmer's model is in its post-reset state |
| rdAck | input | 1 | Host acknowledge of the presented save word (asynchronous) |
| wrData | input | 32 | Restore word offered by the host |
| wrReq | input | 1 | Host offers a restore word (asynchronous) |
| rdValid | output | 1 | A save word is presented |
| rdData | output | 32 | Presented save word |
| wrAck | output | 1 | Restore word taken |
| exAbort | output | 1 | One-cycle stop command to the execution unit |
| modelClear | output | 1 | One-cycle pulse: return to the post-reset state |
| resumeValid | output | 1 | One-cycle pulse: a restored state is ready to resume |
| resumeBusy | output | 1 | The state to resume is mid-operation (valid with resumeValid) |

## Verification
Saves are requested in four activity cases: empty model, quiet unit, a short operation that runs to completion, and a long operation. The frame length and header code tell these cases apart. The remaining count is frozen at 45 and then at 46, which pins down the choice between finishing the operation and aborting it. A save request raised partway through a busy frame shows that a request during a transfer is ignored. Restore frames of each header code, each followed by a save, show which codes reload the context, which raise modelClear or resumeValid, and that code 11 changes nothing.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

  typedef enum logic [1:0] {
    FMT_NULL = 2'b00,
    FMT_IDLE = 2'b01,
    FMT_BUSY = 2'b10,
    FMT_BAD  = 2'b11
  } frameFmt_e;

  typedef struct packed {
    logic      startSave;
    frameFmt_e saveFmt;
    logic      advance;
    logic      startRestore;
    logic      capture;
  } ctlStrobe_t;

endpackage

// File: rtl/ctx_sync.sv
module ctx_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/ctx_save_dp.sv
module ctx_save_dp
  import ctx_save_pkg::*;
#(
  parameter int DW       = 32,
  parameter int IDLE_LEN = 7,
  parameter int BUSY_LEN = 46
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          frameDone,
  output frameFmt_e     curFmt
);
  localparam int LW   = $clog2(BUSY_LEN + 1);
  localparam int CTXN = BUSY_LEN - 1;
  localparam int PADW = DW - 2 - LW;

  logic [LW-1:0] idx;
  logic [LW-1:0] len;
  frameFmt_e     fmt;
  logic [DW-1:0] ctx [CTXN];
  logic [DW-1:0] rdWord;

  function automatic logic [LW-1:0] lenOf(frameFmt_e f);
    case (f)
      FMT_IDLE: lenOf = LW'(IDLE_LEN);
      FMT_BUSY: lenOf = LW'(BUSY_LEN);
      default:  lenOf = LW'(1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
      len <= LW'(1);
      fmt <= FMT_NULL;
    end else if (strb.startSave) begin
      fmt <= strb.saveFmt;
      len <= lenOf(strb.saveFmt);
      idx <= '0;
    end else if (strb.advance) begin
      idx <= idx + LW'(1);
    end else if (strb.startRestore) begin
      fmt <= FMT_NULL;
      len <= LW'(1);
      idx <= '0;
    end else if (strb.capture) begin
      if (idx == '0) begin
        fmt <= frameFmt_e'(wrData[DW-1 -: 2]);
        len <= lenOf(frameFmt_e'(wrData[DW-1 -: 2]));
      end
      idx <= idx + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CTXN; i++) ctx[i] <= '0;
    end else if (strb.capture && !strb.startSave && !strb.startRestore) begin
      for (int i = 0; i < CTXN; i++)
        if (idx == LW'(i + 1)) ctx[i] <= wrData;
    end
  end

  always_comb begin
    rdWord = {fmt, {PADW{1'b0}}, len};
    for (int i = 0; i < CTXN; i++)
      if (idx == LW'(i + 1)) rdWord = ctx[i];
  end

  assign rdData    = rdWord;
  assign frameDone = (idx == len);
  assign curFmt    = fmt;

  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    idx <= len);

  p_hdr_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.startSave |=> (idx == '0));
endmodule

// File: rtl/ctx_save_ctrl.sv
module ctx_save_ctrl
  import ctx_save_pkg::*;
#(
  parameter int RW       = 8,
  parameter int BUSY_LEN = 46
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          saveReq,
  input  logic          restoreReq,
  input  logic          rdAck,
  input  logic          wrReq,
  input  logic          exBusy,
  input  logic [RW-1:0] exRemain,
  input  logic          modelEmpty,
  input  logic          frameDone,
  input  frameFmt_e     curFmt,
  output ctlStrobe_t    strb,
  output logic          rdValid,
  output logic          wrAck,
  output logic          exAbort,
  output logic          modelClear,
  output logic          resumeValid,
  output logic          resumeBusy
);
  localparam logic [RW-1:0] BUSY_RW = RW'(BUSY_LEN);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DRAIN, ST_SEND, ST_SACK, ST_RWAIT, ST_RACK
  } state_e;

  state_e state, stateNext;
  logic [3:0] syncd;
  logic saveS, rstS, ackS, wrS;
  logic saveDly, rstDly;
  logic abortNext, clearNext, resumeNext, busyNext;

  ctx_sync #(.W(4)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({saveReq, restoreReq, rdAck, wrReq}),
    .syncOut(syncd)
  );
  assign {saveS, rstS, ackS, wrS} = syncd;

  wire saveRise = saveS && !saveDly;
  wire rstRise  = rstS && !rstDly;

  always_comb begin
    stateNext  = state;
    strb       = '0;
    abortNext  = 1'b0;
    clearNext  = 1'b0;
    resumeNext = 1'b0;
    busyNext   = resumeBusy;
    case (state)
      ST_IDLE: begin
        if (saveRise) begin
          if (modelEmpty) begin
            strb.startSave = 1'b1; strb.saveFmt = FMT_NULL; stateNext = ST_SEND;
          end else if (!exBusy) begin
            strb.startSave = 1'b1; strb.saveFmt = FMT_IDLE; stateNext = ST_SEND;
          end else if (exRemain < BUSY_RW) begin
            stateNext = ST_DRAIN;
          end else begin
            strb.startSave = 1'b1; strb.saveFmt = FMT_BUSY;
            abortNext = 1'b1; stateNext = ST_SEND;
          end
        end else if (rstRise) begin
          strb.startRestore = 1'b1; stateNext = ST_RWAIT;
        end
      end
      ST_DRAIN: begin
        if (!exBusy) begin
          strb.startSave = 1'b1; strb.saveFmt = FMT_IDLE; stateNext = ST_SEND;
        end
      end
      ST_SEND: begin
        if (ackS) begin
          strb.advance = 1'b1; stateNext = ST_SACK;
        end
      end
      ST_SACK: begin
        if (!ackS) stateNext = frameDone ? ST_IDLE : ST_SEND;
      end
      ST_RWAIT: begin
        if (wrS) begin
          strb.capture = 1'b1; stateNext = ST_RACK;
        end
      end
      ST_RACK: begin
        if (!wrS) begin
          if (frameDone) begin
            stateNext = ST_IDLE;
            case (curFmt)
              FMT_NULL: clearNext = 1'b1;
              FMT_IDLE: begin resumeNext = 1'b1; busyNext = 1'b0; end
              FMT_BUSY: begin resumeNext = 1'b1; busyNext = 1'b1; end
              default:  ;
            endcase
          end else begin
            stateNext = ST_RWAIT;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      saveDly     <= 1'b0;
      rstDly      <= 1'b0;
      exAbort     <= 1'b0;
      modelClear  <= 1'b0;
      resumeValid <= 1'b0;
      resumeBusy  <= 1'b0;
    end else begin
      state       <= stateNext;
      saveDly     <= saveS;
      rstDly      <= rstS;
      exAbort     <= abortNext;
      modelClear  <= clearNext;
      resumeValid <= resumeNext;
      resumeBusy  <= busyNext;
    end
  end

  assign rdValid = (state == ST_SEND);
  assign wrAck   = (state == ST_RACK);

  p_abort_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    exAbort |=> !exAbort);

  p_abort_send_r5: assert property (@(posedge clk) disable iff (!rstN)
    exAbort |-> rdValid);

  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && ackS) |=> !rdValid);

  p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && exBusy) |=> !rdValid);

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(modelClear && resumeValid));
endmodule

// File: rtl/ctx_save_unit.sv
module ctx_save_unit
  import ctx_save_pkg::*;
#(
  parameter int DW       = 32,
  parameter int RW       = 8,
  parameter int IDLE_LEN = 7,
  parameter int BUSY_LEN = 46
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          saveReq,
  input  logic          restoreReq,
  input  logic          exBusy,
  input  logic [RW-1:0] exRemain,
  input  logic          modelEmpty,
  input  logic          rdAck,
  input  logic [DW-1:0] wrData,
  input  logic          wrReq,
  output logic          rdValid,
  output logic [DW-1:0] rdData,
  output logic          wrAck,
  output logic          exAbort,
  output logic          modelClear,
  output logic          resumeValid,
  output logic          resumeBusy
);
  ctlStrobe_t strb;
  logic       frameDone;
  frameFmt_e  curFmt;

  ctx_save_ctrl #(.RW(RW), .BUSY_LEN(BUSY_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .restoreReq(restoreReq),
    .rdAck(rdAck), .wrReq(wrReq), .exBusy(exBusy), .exRemain(exRemain),
    .modelEmpty(modelEmpty), .frameDone(frameDone), .curFmt(curFmt),
    .strb(strb), .rdValid(rdValid), .wrAck(wrAck), .exAbort(exAbort),
    .modelClear(modelClear), .resumeValid(resumeValid), .resumeBusy(resumeBusy)
  );

  ctx_save_dp #(.DW(DW), .IDLE_LEN(IDLE_LEN), .BUSY_LEN(BUSY_LEN)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .frameDone(frameDone), .curFmt(curFmt)
  );
endmodule

// File: tb/ctx_save_unit_tb_top.sv
module ctx_save_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic saveReq = 1'b0, restoreReq = 1'b0, rdAck = 1'b0, wrReq = 1'b0;
  logic modelEmpty = 1'b0;
  logic [31:0] wrData = '0;
  logic exBusy;
  logic [7:0] exRemain;
  logic rdValid, wrAck, exAbort, modelClear, resumeValid, resumeBusy;
  logic [31:0] rdData;

  logic opStart = 1'b0;
  logic run = 1'b1;
  logic [7:0] opLen = '0;

  int testCnt = 0, failCnt = 0;
  int abortCnt = 0, clearCnt = 0, resumeCnt = 0;
  logic lastResumeBusy = 1'b0;
  logic [31:0] model [45];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_save_unit dut_i (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .restoreReq(restoreReq),
    .exBusy(exBusy), .exRemain(exRemain), .modelEmpty(modelEmpty),
    .rdAck(rdAck), .wrData(wrData), .wrReq(wrReq), .rdValid(rdValid),
    .rdData(rdData), .wrAck(wrAck), .exAbort(exAbort), .modelClear(modelClear),
    .resumeValid(resumeValid), .resumeBusy(resumeBusy)
  );

  // stand-in execution unit
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exBusy <= 1'b0; exRemain <= '0;
    end else if (opStart) begin
      exBusy <= 1'b1; exRemain <= opLen;
    end else if (exAbort) begin
      exBusy <= 1'b0;
    end else if (exBusy && run) begin
      if (exRemain == 0) exBusy <= 1'b0;
      else exRemain <= exRemain - 8'd1;
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (exAbort) abortCnt++;
      if (modelClear) clearCnt++;
      if (resumeValid) begin resumeCnt++; lastResumeBusy = resumeBusy; end
    end
  end

  always @(negedge clk) begin
    if (rstN && rdValid && wrAck) begin
      testCnt++; failCnt++;
      $display("FAIL R6: rdValid and wrAck both high act=1 exp=0");
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [1:0] f, input int len);
    return {f, 24'd0, 6'(len)};
  endfunction

  task automatic pulseSave();
    @(negedge clk) saveReq = 1'b1;
    repeat (4) @(negedge clk);
    saveReq = 1'b0;
  endtask

  task automatic pulseRestore();
    @(negedge clk) restoreReq = 1'b1;
    repeat (4) @(negedge clk);
    restoreReq = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic readWord(output logic [31:0] d, output bit ok);
    int n = 0;
    ok = 1'b1;
    @(negedge clk);
    while (!rdValid && n < 3000) begin @(negedge clk); n++; end
    if (!rdValid) begin ok = 1'b0; d = '0; return; end
    d = rdData;
    repeat (2) @(negedge clk);
    rdAck = 1'b1;
    n = 0;
    while (rdValid && n < 50) begin @(negedge clk); n++; end
    rdAck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic readFrame(input logic [1:0] f, input string tag, input int interruptAt);
    int len;
    logic [31:0] d, e;
    bit ok;
    len = (f == 2'b00) ? 1 : (f == 2'b01) ? 7 : 46;
    for (int w = 0; w < len; w++) begin
      if (w == interruptAt) fork pulseSave(); join_none
      readWord(d, ok);
      e = (w == 0) ? hdr(f, len) : model[w-1];
      check(ok && d == e, $sformatf("%s word %0d", tag, w), d, e);
    end
    repeat (25) @(negedge clk);
    check(!rdValid, {tag, " no extra word"}, 32'(rdValid), 32'd0);
  endtask

  task automatic writeWord(input logic [31:0] d);
    int n = 0;
    @(negedge clk) wrData = d;
    @(negedge clk) wrReq = 1'b1;
    while (!wrAck && n < 50) begin @(negedge clk); n++; end
    wrReq = 1'b0;
    n = 0;
    while (wrAck && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic startOp(input logic [7:0] len, input bit doRun);
    @(negedge clk) begin opLen = len; run = doRun; opStart = 1'b1; end
    @(negedge clk) opStart = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int a0, c0, r0;
    for (int i = 0; i < 45; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!rdValid && !wrAck, "R1 handshake outputs", {30'd0, rdValid, wrAck}, 32'd0);
    check(!exAbort && !modelClear && !resumeValid, "R1 pulses",
          {29'd0, exAbort, modelClear, resumeValid}, 32'd0);

    // R2 null frame
    modelEmpty = 1'b1;
    a0 = abortCnt;
    pulseSave();
    readFrame(2'b00, "R2 null", -1);
    check(abortCnt == a0, "R2 no abort", 32'(abortCnt), 32'(a0));
    modelEmpty = 1'b0;

    // R3 idle frame, reset context
    pulseSave();
    readFrame(2'b01, "R3 idle", -1);

    // R7 restore busy frame
    r0 = resumeCnt;
    pulseRestore();
    writeWord(hdr(2'b10, 46));
    for (int i = 0; i < 45; i++) begin
      model[i] = 32'hA500_0000 + 32'(i) * 32'h0101_0101;
      writeWord(model[i]);
    end
    repeat (6) @(negedge clk);
    check(resumeCnt == r0 + 1, "R7 resume pulse busy", 32'(resumeCnt), 32'(r0 + 1));
    check(lastResumeBusy == 1'b1, "R7 resumeBusy", 32'(lastResumeBusy), 32'd1);
    pulseSave();
    readFrame(2'b01, "R7 idle after busy restore", -1);

    // R4 short operation that runs out
    a0 = abortCnt;
    startOp(8'd10, 1'b1);
    pulseSave();
    readFrame(2'b01, "R4 short op", -1);
    check(abortCnt == a0, "R4 short no abort", 32'(abortCnt), 32'(a0));

    // R4 boundary 45, frozen count
    startOp(8'd45, 1'b0);
    pulseSave();
    repeat (30) @(negedge clk);
    check(!rdValid, "R4 hold while busy", 32'(rdValid), 32'd0);
    check(abortCnt == a0, "R4 remain 45 no abort", 32'(abortCnt), 32'(a0));
    run = 1'b1;
    readFrame(2'b01, "R4 remain 45", -1);

    // R5 boundary 46, with R10 request mid-frame
    startOp(8'd46, 1'b0);
    pulseSave();
    readFrame(2'b10, "R5 busy R10", 5);
    check(abortCnt == a0 + 1, "R5 one abort", 32'(abortCnt), 32'(a0 + 1));
    check(!exBusy, "R5 op stopped", 32'(exBusy), 32'd0);
    run = 1'b1;

    // R7 restore idle frame
    r0 = resumeCnt;
    pulseRestore();
    writeWord(hdr(2'b01, 7));
    for (int i = 0; i < 6; i++) begin
      model[i] = 32'h5A5A_0000 + 32'(i);
      writeWord(model[i]);
    end
    repeat (6) @(negedge clk);
    check(resumeCnt == r0 + 1, "R7 resume pulse idle", 32'(resumeCnt), 32'(r0 + 1));
    check(lastResumeBusy == 1'b0, "R7 resumeBusy idle", 32'(lastResumeBusy), 32'd0);
    pulseSave();
    readFrame(2'b01, "R7 idle restored", -1);

    // R9 code 11 header
    r0 = resumeCnt; c0 = clearCnt;
    pulseRestore();
    writeWord(32'hC000_0001);
    repeat (6) @(negedge clk);
    check(resumeCnt == r0 && clearCnt == c0, "R9 no pulses",
          32'(resumeCnt + clearCnt), 32'(r0 + c0));
    check(!wrAck, "R9 no more words taken", 32'(wrAck), 32'd0);
    pulseSave();
    readFrame(2'b01, "R9 context unchanged", -1);

    // R8 null restore
    r0 = resumeCnt; c0 = clearCnt;
    pulseRestore();
    writeWord(hdr(2'b00, 1));
    repeat (6) @(negedge clk);
    check(clearCnt == c0 + 1, "R8 modelClear pulse", 32'(clearCnt), 32'(c0 + 1));
    check(resumeCnt == r0, "R8 no resume", 32'(resumeCnt), 32'(r0));
    modelEmpty = 1'b1;
    pulseSave();
    readFrame(2'b00, "R8 null after clear", -1);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule